// File: doc/BRIEF.md
# Mode-Banked UART Register Front End

This block is the register front end of a 16550-style serial port. A host reaches it through a 32-bit word-addressed read/write port, and only the low byte of each word carries data. Several word offsets are shared: what sits behind an offset depends on the value last written to the line-control register. That value places the block in one of three banks: normal operation, configuration bank A or configuration bank B. The serial shifters, the FIFOs and interrupt generation live elsewhere. This block holds their control bits, exports the character format, produces the FIFO enable and one-cycle FIFO clear strobes, and packs their status signals into a line-status byte.

Several writes are protected. A bit in the enhanced-feature register unlocks writes to the interrupt-enable and FIFO-control registers. A sleep bit in the interrupt-enable register freezes both divisor bytes. FIFO control is accepted only while the baud clock is stopped, which means the 16-bit divisor is zero.

The block also contains the oversampling tick generator. A down-counter reloads from the divisor and emits a one-cycle tick each time it expires. A new divisor therefore takes effect at the next reload. For example, a divisor of 0x1A gives 115200 baud from a 48 MHz clock, and a divisor of 0x138 gives 9600 baud.

Top module: `uart_bank_regs`

## Requirements
- R1: After reset, line control reads 0x00, the mode-select register (offset 0x20) reads 0x07, both divisor bytes read 0x00, interrupt enable reads 0x00, and no baud tick is produced.
- R2: Writing 0xBF to offset 0x0C selects bank B. Any other value with bit 7 set selects bank A. A value with bit 7 clear selects normal operation. The selected bank decides which register answers at offsets 0x00, 0x04, 0x08, 0x10 and 0x14.
- R3: In either configuration bank, offset 0x00 is the divisor low byte and offset 0x04 is the divisor high byte. In normal operation, offset 0x04 is interrupt enable and a read of offset 0x00 returns the `rx_data` input.
- R4: In bank B, offset 0x08 reads and writes the enhanced-feature register. In the other banks, a write to offset 0x08 goes to FIFO control, and a read returns 0xC1 when the FIFOs are enabled or 0x01 when they are not.
- R5: Outside bank B, offset 0x10 is modem control. Offset 0x14 reads a line-status byte and ignores writes. The line-status byte is built as follows: bit 0 is `rx_ready`, bit 5 is `tx_empty`, bits 1, 2, 3, 4 and 7 are `line_err[0]` through `line_err[4]`, and bit 6 is 0. In bank B, offsets 0x10 and 0x14 are two read/write flow-control character bytes.
- R6: Offsets 0x20, 0x24, 0x40, 0x54 and 0x5C are read/write bytes in every bank. Any other offset reads 0, and writes to it change nothing.
- R7: While bit 4 of the enhanced-feature register is 0, writes to interrupt enable and to FIFO control are ignored.
- R8: While bit 4 of interrupt enable is 1, writes to both divisor bytes are ignored.
- R9: A FIFO-control write is accepted only while the 16-bit divisor is zero. On an accepted write, bit 0 becomes `fifo_en`. Bit 1 produces a one-cycle `rx_fifo_clr` pulse and bit 2 produces a one-cycle `tx_fifo_clr` pulse, both in the cycle after the write.
- R10: While `op_sel` is not 7 and the divisor D is non-zero, `baud_tick` pulses exactly once every D cycles. No tick is produced while `op_sel` is 7 or the divisor is zero.
- R11: `char_len` follows line-control bits 1:0, where 3 means 8 data bits. `two_stop` follows bit 2 and `parity_en` follows bit 3.
- R12: In normal operation, a write to offset 0x00 makes `tx_data` carry the written byte with a one-cycle `tx_load` pulse in the next cycle. A read with `rd_en` at offset 0x00 raises `rx_pop` in the same cycle. In the configuration banks, neither strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | BUS_W | Write data (low byte used) |
| rdata | output | BUS_W | Read data for `addr`, zero-extended byte |
| rx_data | input | 8 | Received character from the receive path |
| rx_ready | input | 1 | Receive data available |
| tx_empty | input | 1 | Transmitter empty |
| line_err | input | 5 | Receive error flags |
| tx_data | output | 8 | Character handed to the transmit path |
| tx_load | output | 1 | One-cycle strobe for `tx_data` |
| rx_pop | output | 1 | Receive character consumed |
| baud_tick | output | 1 | Oversampling tick |
| fifo_en | output | 1 | FIFO enable |
| rx_fifo_clr | output | 1 | One-cycle receive FIFO clear |
| tx_fifo_clr | output | 1 | One-cycle transmit FIFO clear |
| char_len | output | 2 | Data bits minus 5 |
| two_stop | output | 1 | Second stop bit select |
| parity_en | output | 1 | Parity enable |
| op_sel | output | 3 | Operating mode select (7 is disabled) |
| int_en | output | 8 | Interrupt enable bits |
| modem_ctl | output | 8 | Modem control bits |

## Verification
The bench builds the block with its defaults, BUS_W=32 and ADDR_W=7. This gives 32 word offsets, few enough to sweep every offset in each of the three banks. It writes all 256 line-control values and checks, for each one, which register answers at the banked offsets. It also drives all 128 combinations of the status inputs through the line-status byte. With the 16-bit divisor it measures the tick period for every divisor from 1 to 40, and for 0x1A and 0x138. It also walks the unlock, sleep and stopped-clock gates in both their locked and unlocked states.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;
  typedef enum logic [1:0] {
    BANK_RUN = 2'd0,
    BANK_CFG_A = 2'd1,
    BANK_CFG_B = 2'd2
  } bank_sel_e;

  localparam logic [7:0] CFG_B_KEY = 8'hBF;
  localparam logic [2:0] OPSEL_OFF = 3'd7;

  // word indices (byte offset / 4)
  localparam logic [31:0] WI_DATA  = 32'd0;
  localparam logic [31:0] WI_DIVHI = 32'd1;
  localparam logic [31:0] WI_FIFO  = 32'd2;
  localparam logic [31:0] WI_LINE  = 32'd3;
  localparam logic [31:0] WI_MODEM = 32'd4;
  localparam logic [31:0] WI_STAT  = 32'd5;
  localparam logic [31:0] WI_OPSEL = 32'd8;
  localparam logic [31:0] WI_AUX2  = 32'd9;
  localparam logic [31:0] WI_SUPP  = 32'd16;
  localparam logic [31:0] WI_SYSC  = 32'd21;
  localparam logic [31:0] WI_WAKE  = 32'd23;
endpackage

// File: rtl/uart_rst_sync.sv
module uart_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/uart_lcr_decode.sv
module uart_lcr_decode
  import uart_bank_pkg::*;
(
  input  logic [7:0] lcr,
  output bank_sel_e  bank,
  output logic [1:0] char_len,
  output logic       two_stop,
  output logic       parity_en
);
  always_comb begin
    if (lcr == CFG_B_KEY) bank = BANK_CFG_B;
    else if (lcr[7])      bank = BANK_CFG_A;
    else                  bank = BANK_RUN;
  end

  assign char_len  = lcr[1:0];
  assign two_stop  = lcr[2];
  assign parity_en = lcr[3];
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == '0);
    cnt_d = cnt_q;
    if (!run)               cnt_d = '0;
    else if (cnt_q == '0)   cnt_d = divisor - DIV_W'(1);
    else                    cnt_d = cnt_q - DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uart_lsr_pack.sv
module uart_lsr_pack (
  input  logic       rx_ready,
  input  logic       tx_empty,
  input  logic [4:0] line_err,
  output logic [7:0] lsr
);
  assign lsr = {line_err[4], 1'b0, tx_empty, line_err[3], line_err[2],
                line_err[1], line_err[0], rx_ready};
endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
  import uart_bank_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic [7:0]        rx_data,
  input  logic              rx_ready,
  input  logic              tx_empty,
  input  logic [4:0]        line_err,
  output logic [7:0]        tx_data,
  output logic              tx_load,
  output logic              rx_pop,
  output logic              baud_tick,
  output logic              fifo_en,
  output logic              rx_fifo_clr,
  output logic              tx_fifo_clr,
  output logic [1:0]        char_len,
  output logic              two_stop,
  output logic              parity_en,
  output logic [2:0]        op_sel,
  output logic [7:0]        int_en,
  output logic [7:0]        modem_ctl
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int DIV_W = 16;

  logic       rst_n;
  bank_sel_e  bank;
  logic [7:0] lsr, wb, rd8;
  logic [31:0] widx;
  logic       in_cfg, in_b, unused_bits;
  logic [DIV_W-1:0] divisor;

  logic [7:0] lcr_q, dll_q, dlh_q, ier_q, efr_q, mcr_q, xon1_q, xon2_q;
  logic [7:0] opsel_q, aux2_q, supp_q, sysc_q, wake_q, txd_q;
  logic       fen_q, rxclr_q, txclr_q, txld_q;
  logic [7:0] lcr_d, dll_d, dlh_d, ier_d, efr_d, mcr_d, xon1_d, xon2_d;
  logic [7:0] opsel_d, aux2_d, supp_d, sysc_d, wake_d, txd_d;
  logic       fen_d, rxclr_d, txclr_d, txld_d;

  uart_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .rst_n_sync(rst_n));

  uart_lcr_decode u_dec (
    .lcr(lcr_q), .bank(bank), .char_len(char_len),
    .two_stop(two_stop), .parity_en(parity_en)
  );

  uart_lsr_pack u_lsr (
    .rx_ready(rx_ready), .tx_empty(tx_empty), .line_err(line_err), .lsr(lsr)
  );

  assign divisor = {dlh_q, dll_q};

  uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n),
    .run((opsel_q[2:0] != OPSEL_OFF) && (divisor != '0)),
    .divisor(divisor), .tick(baud_tick)
  );

  assign widx        = 32'(addr[ADDR_W-1:2]);
  assign wb          = wdata[7:0];
  assign in_cfg      = (bank != BANK_RUN);
  assign in_b        = (bank == BANK_CFG_B);
  assign unused_bits = ^{wdata[BUS_W-1:8], addr[1:0]};

  // next-state
  always_comb begin
    lcr_d = lcr_q;  dll_d = dll_q;  dlh_d = dlh_q;  ier_d = ier_q;
    efr_d = efr_q;  mcr_d = mcr_q;  xon1_d = xon1_q; xon2_d = xon2_q;
    opsel_d = opsel_q; aux2_d = aux2_q; supp_d = supp_q;
    sysc_d = sysc_q; wake_d = wake_q; txd_d = txd_q; fen_d = fen_q;
    rxclr_d = 1'b0; txclr_d = 1'b0; txld_d = 1'b0;
    if (wr_en) begin
      case (widx)
        WI_DATA: begin
          if (in_cfg) begin
            if (!ier_q[4]) dll_d = wb;
          end else begin
            txd_d  = wb;
            txld_d = 1'b1;
          end
        end
        WI_DIVHI: begin
          if (in_cfg) begin
            if (!ier_q[4]) dlh_d = wb;
          end else if (efr_q[4]) begin
            ier_d = wb;
          end
        end
        WI_FIFO: begin
          if (in_b) efr_d = wb;
          else if (efr_q[4] && (divisor == '0)) begin
            fen_d   = wb[0];
            rxclr_d = wb[1];
            txclr_d = wb[2];
          end
        end
        WI_LINE:  lcr_d = wb;
        WI_MODEM: if (in_b) xon1_d = wb; else mcr_d = wb;
        WI_STAT:  if (in_b) xon2_d = wb;
        WI_OPSEL: opsel_d = wb;
        WI_AUX2:  aux2_d = wb;
        WI_SUPP:  supp_d = wb;
        WI_SYSC:  sysc_d = wb;
        WI_WAKE:  wake_d = wb;
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q <= '0; dll_q <= '0; dlh_q <= '0; ier_q <= '0;
      efr_q <= '0; mcr_q <= '0; xon1_q <= '0; xon2_q <= '0;
      opsel_q <= {5'd0, OPSEL_OFF}; aux2_q <= '0; supp_q <= '0;
      sysc_q <= '0; wake_q <= '0; txd_q <= '0; fen_q <= 1'b0;
      rxclr_q <= 1'b0; txclr_q <= 1'b0; txld_q <= 1'b0;
    end else begin
      lcr_q <= lcr_d; dll_q <= dll_d; dlh_q <= dlh_d; ier_q <= ier_d;
      efr_q <= efr_d; mcr_q <= mcr_d; xon1_q <= xon1_d; xon2_q <= xon2_d;
      opsel_q <= opsel_d; aux2_q <= aux2_d; supp_q <= supp_d;
      sysc_q <= sysc_d; wake_q <= wake_d; txd_q <= txd_d; fen_q <= fen_d;
      rxclr_q <= rxclr_d; txclr_q <= txclr_d; txld_q <= txld_d;
    end
  end

  // read mux
  always_comb begin
    case (widx)
      WI_DATA:  rd8 = in_cfg ? dll_q : rx_data;
      WI_DIVHI: rd8 = in_cfg ? dlh_q : ier_q;
      WI_FIFO:  rd8 = in_b ? efr_q : {fen_q, fen_q, 6'b000001};
      WI_LINE:  rd8 = lcr_q;
      WI_MODEM: rd8 = in_b ? xon1_q : mcr_q;
      WI_STAT:  rd8 = in_b ? xon2_q : lsr;
      WI_OPSEL: rd8 = opsel_q;
      WI_AUX2:  rd8 = aux2_q;
      WI_SUPP:  rd8 = supp_q;
      WI_SYSC:  rd8 = sysc_q;
      WI_WAKE:  rd8 = wake_q;
      default:  rd8 = 8'h00;
    endcase
  end

  assign rdata       = {{(BUS_W-8){1'b0}}, rd8};
  assign rx_pop      = rd_en && (widx == WI_DATA) && !in_cfg;
  assign tx_data     = txd_q;
  assign tx_load     = txld_q;
  assign fifo_en     = fen_q;
  assign rx_fifo_clr = rxclr_q;
  assign tx_fifo_clr = txclr_q;
  assign op_sel      = opsel_q[2:0];
  assign int_en      = ier_q;
  assign modem_ctl   = mcr_q;
endmodule

// File: rtl/uart_bank_regs_chk.sv
module uart_bank_regs_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        lcr_q,
  input logic [7:0]        ier_q,
  input logic              efr_unlock,
  input logic [7:0]        dll_q,
  input logic [7:0]        dlh_q,
  input logic [2:0]        op_sel,
  input logic              fifo_en,
  input logic              baud_tick,
  input logic              rx_fifo_clr,
  input logic              tx_load
);
  localparam logic [ADDR_W-3:0] FIFO_IDX = (ADDR_W-2)'(2);

  assert_tick_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_sel == 3'd7) || ({dlh_q, dll_q} == 16'd0)) |-> !baud_tick);

  assert_div_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ier_q[4]) |-> ($stable(dll_q) && $stable(dlh_q)));

  assert_ier_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(efr_unlock) |-> $stable(ier_q));

  assert_fifo_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past({dlh_q, dll_q}) != 16'd0) |-> $stable(fifo_en));

  assert_clr_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fifo_clr |-> ($past(wr_en) && ($past(addr[ADDR_W-1:2]) == FIFO_IDX)));

  assert_tx_run_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> !$past(lcr_q[7]));
endmodule

bind uart_bank_regs uart_bank_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .lcr_q(lcr_q), .ier_q(ier_q), .efr_unlock(efr_q[4]),
  .dll_q(dll_q), .dlh_q(dlh_q), .op_sel(op_sel), .fifo_en(fifo_en),
  .baud_tick(baud_tick), .rx_fifo_clr(rx_fifo_clr), .tx_load(tx_load)
);

// File: tb/sim_uart_bank_regs.sv
`timescale 1ns/1ps
module sim_uart_bank_regs;
  logic        clk = 1'b0;
  logic        arst_n;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_ready = 1'b0, tx_empty = 1'b0;
  logic [4:0]  line_err = '0;
  logic [7:0]  tx_data, int_en, modem_ctl;
  logic        tx_load, rx_pop, baud_tick, fifo_en, rx_fifo_clr, tx_fifo_clr;
  logic [1:0]  char_len;
  logic        two_stop, parity_en;
  logic [2:0]  op_sel;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  uart_bank_regs u0 (
    .clk(clk), .arst_n(arst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_empty(tx_empty), .line_err(line_err), .tx_data(tx_data),
    .tx_load(tx_load), .rx_pop(rx_pop), .baud_tick(baud_tick),
    .fifo_en(fifo_en), .rx_fifo_clr(rx_fifo_clr), .tx_fifo_clr(tx_fifo_clr),
    .char_len(char_len), .two_stop(two_stop), .parity_en(parity_en),
    .op_sel(op_sel), .int_en(int_en), .modem_ctl(modem_ctl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int off, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; addr = off[6:0]; wdata = {24'h0, v};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int off, output logic [31:0] v);
    @(negedge clk);
    addr = off[6:0];
    #1 v = rdata;
  endtask

  function automatic bit mapped(input int w);
    return (w <= 5) || (w == 8) || (w == 9) || (w == 16) || (w == 21) || (w == 23);
  endfunction

  task automatic count_ticks(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (baud_tick) n++;
    end
  endtask

  task automatic measure(input logic [15:0] d);
    int g, n;
    wr(12, 8'h80); wr(32, 8'h07);
    wr(4, d[15:8]); wr(0, d[7:0]); wr(32, 8'h00);
    g = 0;
    while (!baud_tick && g < 2000) begin @(negedge clk); g++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!baud_tick && n < 2000);
    chk($sformatf("R10 period div=%0d", d), n, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    arst_n = 1'b1;
    #1 arst_n = 1'b0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(12, v); chk("R1 line control", v, 0);
    rd(32, v); chk("R1 mode select", v, 32'h07);
    rd(4, v);  chk("R1 interrupt enable", v, 0);
    count_ticks(50, n); chk("R1 no tick", n, 0);
    wr(12, 8'h80);
    rd(0, v); chk("R1 divisor low", v, 0);
    rd(4, v); chk("R1 divisor high", v, 0);

    // R11 character format, all low-nibble values
    for (int i = 0; i < 16; i++) begin
      wr(12, i[7:0]);
      chk("R11 char_len", {30'd0, char_len}, i & 3);
      chk("R11 two_stop", {31'd0, two_stop}, (i >> 2) & 1);
      chk("R11 parity_en", {31'd0, parity_en}, (i >> 3) & 1);
    end

    // R3 divisor vs data/interrupt-enable banking
    wr(12, 8'h80); wr(0, 8'h12); wr(4, 8'h34);
    rd(0, v); chk("R3 bank A divisor low", v, 32'h12);
    rd(4, v); chk("R3 bank A divisor high", v, 32'h34);
    wr(12, 8'hBF);
    rd(0, v); chk("R3 bank B divisor low", v, 32'h12);
    wr(12, 8'h03); rx_data = 8'hA5;
    rd(0, v); chk("R3 run rx data", v, 32'hA5);
    rd(4, v); chk("R3 run interrupt enable", v, 0);

    // R2 sweep of every line-control value
    wr(12, 8'hBF); wr(8, 8'h10); wr(16, 8'h3C);
    wr(12, 8'h00); wr(16, 8'h0B);
    for (int i = 0; i < 256; i++) begin
      wr(12, i[7:0]);
      rd(8, v);  chk($sformatf("R2 off8 lcr=%02h", i), v, (i == 8'hBF) ? 32'h10 : 32'h01);
      rd(16, v); chk($sformatf("R2 off16 lcr=%02h", i), v, (i == 8'hBF) ? 32'h3C : 32'h0B);
      rd(0, v);  chk($sformatf("R2 off0 lcr=%02h", i), v, (i >= 128) ? 32'h12 : 32'hA5);
    end
    wr(12, 8'h03);
    chk("R5 modem_ctl port", {24'd0, modem_ctl}, 32'h0B);

    // R7 lock gate
    wr(12, 8'hBF); wr(8, 8'h00); wr(12, 8'h80); wr(0, 8'h00); wr(4, 8'h00);
    wr(12, 8'h03); wr(4, 8'h0F);
    rd(4, v); chk("R7 locked interrupt enable", v, 0);
    wr(8, 8'h07);
    chk("R7 locked fifo clr", {31'd0, rx_fifo_clr}, 0);
    chk("R7 locked fifo_en", {31'd0, fifo_en}, 0);
    wr(12, 8'hBF); wr(8, 8'h10); wr(12, 8'h03); wr(4, 8'h0F);
    rd(4, v); chk("R7 unlocked interrupt enable", v, 32'h0F);
    chk("R7 int_en port", {24'd0, int_en}, 32'h0F);

    // R9 / R4 FIFO control
    wr(8, 8'h07);
    chk("R9 rx clr pulse", {31'd0, rx_fifo_clr}, 1);
    chk("R9 tx clr pulse", {31'd0, tx_fifo_clr}, 1);
    chk("R9 fifo_en set", {31'd0, fifo_en}, 1);
    @(negedge clk);
    chk("R9 rx clr one cycle", {31'd0, rx_fifo_clr}, 0);
    chk("R9 tx clr one cycle", {31'd0, tx_fifo_clr}, 0);
    rd(8, v); chk("R4 ident fifo on", v, 32'hC1);
    wr(8, 8'h02);
    chk("R9 rx only", {31'd0, rx_fifo_clr}, 1);
    chk("R9 tx not", {31'd0, tx_fifo_clr}, 0);
    chk("R9 fifo_en cleared", {31'd0, fifo_en}, 0);
    wr(12, 8'h80); wr(0, 8'h05); wr(12, 8'h03); wr(8, 8'h07);
    chk("R9 blocked by divisor fifo_en", {31'd0, fifo_en}, 0);
    chk("R9 blocked by divisor clr", {31'd0, rx_fifo_clr}, 0);

    // R8 sleep gate
    wr(4, 8'h10); wr(12, 8'h80); wr(0, 8'h09); wr(4, 8'h01);
    rd(0, v); chk("R8 sleep divisor low", v, 32'h05);
    rd(4, v); chk("R8 sleep divisor high", v, 0);
    wr(12, 8'h03); wr(4, 8'h00); wr(12, 8'h80); wr(0, 8'h09);
    rd(0, v); chk("R8 awake divisor low", v, 32'h09);

    // R6 common and unmapped offsets in each bank
    for (int m = 0; m < 3; m++) begin
      logic [7:0] lv;
      lv = (m == 0) ? 8'h03 : (m == 1) ? 8'h80 : 8'hBF;
      wr(12, lv);
      for (int k = 0; k < 5; k++) begin
        int off;
        logic [7:0] pv;
        off = (k == 0) ? 32 : (k == 1) ? 36 : (k == 2) ? 64 : (k == 3) ? 84 : 92;
        pv = 8'(8'h5A ^ (m * 16 + k * 7 + 1));
        if (k == 0) pv = {pv[7:3], 3'd7};
        wr(off, pv);
        rd(off, v); chk($sformatf("R6 common off=%0h bank=%0d", off, m), v, {24'd0, pv});
      end
      for (int w = 0; w < 32; w++) begin
        if (!mapped(w)) begin
          wr(w * 4, 8'hFF);
          rd(w * 4, v); chk($sformatf("R6 unmapped w=%0d bank=%0d", w, m), v, 0);
        end
      end
      rd(36, v); chk("R6 untouched by unmapped", v, {24'd0, 8'(8'h5A ^ (m * 16 + 8))});
    end

    // R5 line status sweep and bank B characters
    wr(12, 8'h03);
    for (int i = 0; i < 128; i++) begin
      logic [7:0] e;
      rx_ready = i[0]; tx_empty = i[1]; line_err = i[6:2];
      e = {i[6], 1'b0, i[1], i[5], i[4], i[3], i[2], i[0]};
      rd(20, v); chk($sformatf("R5 status in=%0d", i), v, {24'd0, e});
    end
    rx_ready = 0; tx_empty = 0; line_err = '0;
    wr(20, 8'hFF);
    rd(20, v); chk("R5 status write ignored", v, 0);
    wr(12, 8'hBF); wr(20, 8'h66);
    rd(20, v); chk("R5 bank B char2", v, 32'h66);

    // R12 data strobes
    wr(12, 8'h03); wr(0, 8'h5A);
    chk("R12 tx_load", {31'd0, tx_load}, 1);
    chk("R12 tx_data", {24'd0, tx_data}, 32'h5A);
    @(negedge clk);
    chk("R12 tx_load one cycle", {31'd0, tx_load}, 0);
    @(negedge clk); rd_en = 1'b1; addr = 7'd0;
    #1 chk("R12 rx_pop run", {31'd0, rx_pop}, 1);
    @(negedge clk); rd_en = 1'b0;
    wr(12, 8'h80); wr(0, 8'h77);
    chk("R12 no tx_load in cfg", {31'd0, tx_load}, 0);
    @(negedge clk); rd_en = 1'b1; addr = 7'd0;
    #1 chk("R12 no rx_pop in cfg", {31'd0, rx_pop}, 0);
    @(negedge clk); rd_en = 1'b0;

    // R10 tick period sweep
    for (int d = 1; d <= 40; d++) measure(16'(d));
    measure(16'h001A);
    measure(16'h0138);
    wr(32, 8'h07);
    chk("R10 op_sel port", {29'd0, op_sel}, 7);
    count_ticks(400, n); chk("R10 disabled no tick", n, 0);
    wr(32, 8'h00); wr(4, 8'h00); wr(0, 8'h00);
    count_ticks(100, n); chk("R10 zero divisor no tick", n, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule